// File: doc/BRIEF.md
# Pipelined Escape-Time Iteration Array

This block runs the escape-time test for points of the complex plane. Each point `c = cx + i*cy` goes through a chain of identical stages, and each stage applies one step of the recurrence `z <- z*z + c`, starting from `z = 0`. The chain is fully pipelined. It accepts one point every clock, and each point advances one stage per clock together with its own `c`, current `z`, escape flag and iteration count.

A point is escaped when `x*x + y*y` exceeds 4. The stage that finds this freezes the point's `z` and count. The point then passes through the remaining stages unchanged. At the end of the chain the block presents the count and a valid strobe. A count equal to the stage total means the point never escaped. The surrounding logic pairs a result with its input by position in the stream, because the latency is fixed.

Top module: `escape_iter_array`

## Requirements
- R1: A sample presented with `in_valid` high at a rising edge appears on the outputs exactly `N_STAGES` rising edges later, and `out_valid` is `in_valid` delayed by that many edges.
- R2: Synchronous active-low reset clears every stage. In the cycle after a rising edge with `rst_n` low, `out_valid` is 0 and `out_count` is 0.
- R3: An empty slot leaves the chain with `out_count` equal to 0, and slots are independent. A point's result does not depend on the points or bubbles before or after it.
- R4: `cx`, `cy` and the internal `z` components are W-bit signed two's complement values with FRAC fractional bits. The defaults are W=13 and FRAC=10.
- R5: A stage that holds a live point first computes `m = x*x + y*y` at full precision. If `m > 4*2^(2*FRAC)`, the stage marks the point escaped. Otherwise it sets `x' = wrapW(floor((x*x - y*y)/2^FRAC) + cx)` and `y' = wrapW(floor(x*y/2^(FRAC-1)) + cy)`, and increments the count. `wrapW` keeps the low W bits as signed.
- R6: After a point escapes, every later stage keeps its `z` and count unchanged. `out_count` is the number of updates performed, from 1 to `N_STAGES`, and it equals `N_STAGES` when the point never escaped.
- R7: The escape test is strict. A magnitude of exactly 2 does not escape, so `c = -2` yields `N_STAGES`.
- R8: A new point can enter on every clock. Back-to-back points each produce their own correct result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | A point is present this cycle |
| in_cx | input | W | Real part of c, signed fixed point |
| in_cy | input | W | Imaginary part of c, signed fixed point |
| out_valid | output | 1 | A result is present this cycle |
| out_count | output | $clog2(N_STAGES+1) | Number of iterations before escape, or N_STAGES |

## Verification
A corrupted `z`, a wrong rounding shift or a misplaced escape decision changes the count of most points that pass through. The error shows on `out_count` exactly `N_STAGES` cycles after the point enters. A freeze that leaks, where an escaped point is still updated, shows as a count that is too high within the same pass. The bench compares every output slot against an independent model, so a wrong value is reported in the cycle it appears. A slip in the valid alignment is visible on the very first live point.

// File: rtl/escape_iter_pkg.sv
// Shared defaults for the escape-time iteration array.
package escape_iter_pkg;
    localparam int DEF_W      = 13;  // operand width
    localparam int DEF_FRAC   = 10;  // fractional bits
    localparam int DEF_STAGES = 9;   // iteration stages
endpackage

// File: rtl/escape_square.sv
// Complex-square helper: the three full-precision products of z.
// Assumes signed two's complement inputs; products are exact, 2W bits.
module escape_square #(
    parameter int W = 13
) (
    input  logic signed [W-1:0]   zx,
    input  logic signed [W-1:0]   zy,
    output logic signed [2*W-1:0] xx,
    output logic signed [2*W-1:0] yy,
    output logic signed [2*W-1:0] xy
);
    // Three inferred multipliers.
    always_comb begin
        xx = zx * zx;
        yy = zy * zy;
        xy = zx * zy;
    end
endmodule

// File: rtl/escape_stage.sv
// One iteration stage: tests |z|>2, then either freezes the point or
// advances z <- z^2 + c and bumps its count. Registers all outputs.
// Assumes FRAC >= 1 and FRAC <= W-1.
module escape_stage #(
    parameter int W    = 13,
    parameter int FRAC = 10,
    parameter int CW   = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                v_i,
    input  logic                e_i,
    input  logic [CW-1:0]       n_i,
    input  logic signed [W-1:0] cx_i,
    input  logic signed [W-1:0] cy_i,
    input  logic signed [W-1:0] zx_i,
    input  logic signed [W-1:0] zy_i,
    output logic                v_o,
    output logic                e_o,
    output logic [CW-1:0]       n_o,
    output logic signed [W-1:0] cx_o,
    output logic signed [W-1:0] cy_o,
    output logic signed [W-1:0] zx_o,
    output logic signed [W-1:0] zy_o
);
    localparam int PW = 2 * W + 2;
    localparam logic signed [PW-1:0] LIMIT = {{(PW-1){1'b0}}, 1'b1} << (2 * FRAC + 2);

    logic signed [2*W-1:0] xx, yy, xy;
    logic signed [PW-1:0]  xx_e, yy_e, mag, dif, nx_w, ny_w;
    logic                  over;

    escape_square #(.W(W)) u_sq (.zx(zx_i), .zy(zy_i), .xx(xx), .yy(yy), .xy(xy));

    // Escape test and next-z arithmetic at full precision.
    always_comb begin
        xx_e = {{2{xx[2*W-1]}}, xx};
        yy_e = {{2{yy[2*W-1]}}, yy};
        mag  = xx_e + yy_e;
        over = mag > LIMIT;
        dif  = xx_e - yy_e;
        nx_w = (dif >>> FRAC) + {{(PW-W){cx_i[W-1]}}, cx_i};
        ny_w = ({{2{xy[2*W-1]}}, xy} >>> (FRAC - 1)) + {{(PW-W){cy_i[W-1]}}, cy_i};
    end

    // Stage register: clear on reset or bubble, freeze or advance otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n || !v_i) begin
            v_o  <= 1'b0;
            e_o  <= 1'b0;
            n_o  <= '0;
            cx_o <= '0;
            cy_o <= '0;
            zx_o <= '0;
            zy_o <= '0;
        end else begin
            v_o  <= 1'b1;
            cx_o <= cx_i;
            cy_o <= cy_i;
            if (e_i || over) begin
                e_o  <= 1'b1;
                n_o  <= n_i;
                zx_o <= zx_i;
                zy_o <= zy_i;
            end else begin
                e_o  <= 1'b0;
                n_o  <= n_i + CW'(1);
                zx_o <= nx_w[W-1:0];
                zy_o <= ny_w[W-1:0];
            end
        end
    end
endmodule

// File: rtl/escape_iter_array.sv
// Linear systolic chain of N_STAGES escape stages. One point per clock,
// latency N_STAGES. Output count is the iteration count, or N_STAGES
// for points that never escaped; empty slots report zero.
module escape_iter_array #(
    parameter int W        = escape_iter_pkg::DEF_W,
    parameter int FRAC     = escape_iter_pkg::DEF_FRAC,
    parameter int N_STAGES = escape_iter_pkg::DEF_STAGES
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               in_valid,
    input  logic signed [W-1:0]                in_cx,
    input  logic signed [W-1:0]                in_cy,
    output logic                               out_valid,
    output logic [$clog2(N_STAGES+1)-1:0]      out_count
);
    localparam int CNT_W = $clog2(N_STAGES + 1);

    logic [N_STAGES:0]            v_a, e_a;
    logic [N_STAGES:0][CNT_W-1:0] cnt_a;
    logic signed [W-1:0]          cx_a [N_STAGES+1];
    logic signed [W-1:0]          cy_a [N_STAGES+1];
    logic signed [W-1:0]          zx_a [N_STAGES+1];
    logic signed [W-1:0]          zy_a [N_STAGES+1];

    // Chain head: fresh point with z = 0, not escaped, count 0.
    always_comb begin
        v_a[0]   = in_valid;
        e_a[0]   = 1'b0;
        cnt_a[0] = '0;
        cx_a[0]  = in_cx;
        cy_a[0]  = in_cy;
        zx_a[0]  = '0;
        zy_a[0]  = '0;
    end

    for (genvar k = 0; k < N_STAGES; k++) begin : g_stage
        escape_stage #(.W(W), .FRAC(FRAC), .CW(CNT_W)) u_stage (
            .clk  (clk),
            .rst_n(rst_n),
            .v_i  (v_a[k]),
            .e_i  (e_a[k]),
            .n_i  (cnt_a[k]),
            .cx_i (cx_a[k]),
            .cy_i (cy_a[k]),
            .zx_i (zx_a[k]),
            .zy_i (zy_a[k]),
            .v_o  (v_a[k+1]),
            .e_o  (e_a[k+1]),
            .n_o  (cnt_a[k+1]),
            .cx_o (cx_a[k+1]),
            .cy_o (cy_a[k+1]),
            .zx_o (zx_a[k+1]),
            .zy_o (zy_a[k+1])
        );
    end

    // Chain tail drives the result ports.
    always_comb begin
        out_valid = v_a[N_STAGES];
        out_count = cnt_a[N_STAGES];
    end
endmodule

// File: rtl/escape_iter_array_chk.sv
// Property checker for escape_iter_array, attached by bind.
module escape_iter_array_chk #(
    parameter int N_STAGES = 9,
    parameter int CNT_W    = 4
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          in_valid,
    input logic                          out_valid,
    input logic [CNT_W-1:0]              out_count,
    input logic [N_STAGES:0]             v_a,
    input logic [N_STAGES:0]             e_a,
    input logic [N_STAGES:0][CNT_W-1:0]  cnt_a
);
    logic [N_STAGES-1:0] vshadow;

    // Shadow delay line of the input strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) vshadow <= '0;
        else        vshadow <= {vshadow[N_STAGES-2:0], in_valid};
    end

    assert_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == vshadow[N_STAGES-1]);

    assert_reset_R2: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_count == '0));

    assert_bubble_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> out_count == '0);

    assert_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_count >= CNT_W'(1) && out_count <= CNT_W'(N_STAGES)));

    for (genvar k = 1; k <= N_STAGES; k++) begin : g_chk
        assert_live_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (v_a[k] && !e_a[k]) |-> cnt_a[k] == CNT_W'(k));
        if (k < N_STAGES) begin : g_frz
            assert_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
                (v_a[k] && e_a[k]) |=> (v_a[k+1] && e_a[k+1] && cnt_a[k+1] == $past(cnt_a[k])));
        end
    end
endmodule

bind escape_iter_array escape_iter_array_chk #(.N_STAGES(N_STAGES), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_valid(out_valid),
    .out_count(out_count), .v_a(v_a), .e_a(e_a), .cnt_a(cnt_a)
);

// File: tb/escape_iter_array_bench.sv
module escape_iter_array_bench;
    localparam int  W = 13, FRAC = 10, N = 9;
    localparam int  CW = $clog2(N + 1);
    localparam time CLK_PERIOD = 10ns;

    logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
    logic signed [W-1:0] in_cx = '0, in_cy = '0;
    logic out_valid;
    logic [CW-1:0] out_count;
    int checks = 0, errors = 0;
    bit done = 0;

    typedef struct { bit v; int cnt; } exp_t;
    exp_t q[$];

    escape_iter_array #(.W(W), .FRAC(FRAC), .N_STAGES(N)) u_escape_iter_array (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_cx(in_cx), .in_cy(in_cy),
        .out_valid(out_valid), .out_count(out_count));

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic longint wrapw(longint v);
        longint t = v & ((64'sd1 <<< W) - 1);
        if (t >= (64'sd1 <<< (W - 1))) t -= (64'sd1 <<< W);
        return t;
    endfunction

    // Behavioural escape-time count (R4, R5, R6, R7).
    function automatic int ref_count(longint cx, longint cy);
        longint x = 0, y = 0, nx, ny;
        int n = 0;
        for (int i = 0; i < N; i++) begin
            if (x * x + y * y > (64'sd4 <<< (2 * FRAC))) break;
            nx = wrapw(((x * x - y * y) >>> FRAC) + cx);
            ny = wrapw(((x * y) >>> (FRAC - 1)) + cy);
            x = nx; y = ny; n++;
        end
        return n;
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // One cycle: compare the slot due now, then drive the next input.
    task automatic step(bit rst, bit v, longint cx, longint cy);
        exp_t e;
        @(negedge clk);
        if (q.size() == N) begin
            e = q.pop_front();
            if (!e.v)
                check(out_valid === 1'b0 && out_count === CW'(0), "R3 empty slot (R1 latency)",
                      int'({out_valid, out_count}), 0);
            else
                check(out_valid === 1'b1 && int'(out_count) == e.cnt,
                      e.cnt == N ? "R6 no-escape count (R1 latency)" : "R5 escape count (R1 latency)",
                      int'(out_count), e.cnt);
        end
        rst_n = rst;
        in_valid = v;
        in_cx = cx[W-1:0];
        in_cy = cy[W-1:0];
        if (!rst) foreach (q[i]) begin q[i].v = 0; q[i].cnt = 0; end
        e.v = v && rst;
        e.cnt = e.v ? ref_count(wrapw(cx), wrapw(cy)) : 0;
        q.push_back(e);
    endtask

    localparam longint ONE = 64'sd1 <<< FRAC;

    initial begin
        for (int i = 0; i < N + 2; i++) step(0, 0, 0, 0);
        @(negedge clk);
        check(out_valid === 1'b0 && out_count === CW'(0), "R2 reset state", int'(out_valid), 0);
        // Corner points, back to back (R8).
        step(1, 1, 0, 0);                 // never escapes
        step(1, 1, -2 * ONE, 0);          // R7 boundary, |z| = 2 exactly
        step(1, 1, 3 * ONE, 0);           // escapes after one update
        step(1, 1, ONE, 0);               // wraps then escapes (R4)
        step(1, 1, 0, ONE);               // period-2 cycle
        step(1, 1, -4 * ONE, -4 * ONE);   // most negative operands
        step(1, 1, ONE / 4 + 20, 0);      // slow escape near cusp
        step(1, 1, -ONE, ONE / 4);
        // Random stream, every cycle (R8).
        for (int i = 0; i < 300; i++) step(1, 1, $urandom % 8192, $urandom % 8192);
        // Bubbles interleaved (R3).
        for (int i = 0; i < 200; i++) step(1, (i % 3) != 1, $urandom % 8192, $urandom % 8192);
        // Mid-stream reset (R2), then recovery.
        step(0, 1, ONE, 0);
        step(0, 1, ONE, 0);
        for (int i = 0; i < 100; i++) step(1, 1, $urandom % 8192, $urandom % 8192);
        for (int i = 0; i < N + 1; i++) step(1, 0, 0, 0);
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            done = 1;
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule